// File: doc/BRIEF.md
# Tick Counter with Compare Interrupt

This block keeps a free-running tick count and raises a soft-interrupt request when the count reaches a programmed compare value. The count is 63 bits wide. The top bit of the 64-bit register word is a disable flag: writing either the count or the compare value sets or clears it, and it shows in bit 63 whenever the count is read. A one-cycle `tick_en` strobe moves the counter forward, so any rate scaling stays outside the block. The nominal strobe rate is 100 MHz.

The compare is one-shot. Each write of a non-zero compare value arms it once. When the count has caught up with that value, it fires a single time on a tick and then stays quiet until software writes a new compare value. A compare value whose low 63 bits are zero never arms. A compare value at or below the current count fires on the first tick after the write.

The same RTL serves three roles, selected by a parameter. The CPU-tick role sets soft-interrupt bit 0. The system-tick and hypervisor-tick roles both set soft-interrupt bit 16.

Top module: `tick_cmp_timer`

## Requirements
- R1: After reset, `rd_data` reads 64'h8000_0000_0000_0000: the disable flag is set, the count is zero and no compare is armed. `softint_set` is all zeros.
- R2: A count write (`wr_en`=1, `wr_sel`=0) loads `wr_data[62:0]` into the counter and `wr_data[63]` into the disable flag. Both are visible on `rd_data` in the next cycle.
- R3: Each cycle with `tick_en`=1 and no write adds one to the count. Without a tick the count holds. The count advances whether or not the flag is set.
- R4: `rd_data` is the 63-bit count in bits 62:0 with the disable flag in bit 63.
- R5: With a compare armed and the flag clear, the tick that brings the count up to the compare value makes `softint_set` show a single one-cycle pulse. The pulse appears in the same cycle that `rd_data` first shows that count.
- R6: A compare write whose low 63 bits are zero never produces a pulse.
- R7: A compare write (`wr_sel`=1) whose value is at or below the current count fires on the first tick after the write.
- R8: A compare write loads `wr_data[63]` into the disable flag. No pulse occurs while the flag is set. An armed compare stays armed and can fire once a count write clears the flag.
- R9: After firing, the compare stays quiet on later ticks until a new compare write arms it again.
- R10: The counter wraps from 0x7FFF_FFFF_FFFF_FFFF to 0 without a pulse, and a compare armed above zero still fires when the count later reaches it.
- R11: The CPU-tick role (KIND=TK_CPU) pulses bit 0 of `softint_set`. The system-tick and hypervisor-tick roles pulse bit 16.
- R12: A write in the same cycle as `tick_en` takes priority. That tick is dropped: the count takes exactly the written value (or holds on a compare write), and no pulse comes from that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count-advance strobe |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 count, 1 compare value |
| wr_data | input | 64 | Write data; bit 63 is the disable flag |
| rd_data | output | 64 | Count read value with the disable flag in bit 63 |
| softint_set | output | 17 | One-cycle soft-interrupt set pulse |

## Verification
The coincidence that matters is a register write landing in the same cycle as a tick strobe. Write priority then decides both the count and whether a match is taken. The bench provokes this in two ways. First, it writes a count with `tick_en` high and expects exactly the written value back, not one more. Second, it writes a compare value with `tick_en` high and expects the count to hold with no pulse, and the pulse to arrive only on the third following tick. Matching on the tick that wraps the counter is a second hazard. The bench judges it by watching for a pulse across the wrap and again at the later count.

// File: rtl/tick_cmp_pkg.sv
package tick_cmp_pkg;

   typedef enum logic [1:0] {
      TK_CPU = 2'd0,
      TK_SYS = 2'd1,
      TK_HYP = 2'd2
   } tick_kind_e;

   // soft-interrupt bit that each role raises on a match
   function automatic int softint_pos(tick_kind_e k);
      return (k == TK_CPU) ? 0 : 16;
   endfunction

endpackage

// File: rtl/tick_cnt_core.sv
module tick_cnt_core #(
   parameter int CNT_W = 63
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   input  logic             ld_cnt,
   input  logic [CNT_W-1:0] ld_val,
   input  logic             ld_flag,
   input  logic             flag_val,
   output logic [CNT_W-1:0] cnt_q,
   output logic [CNT_W-1:0] cnt_inc,
   output logic             dis_q
);
   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   // wraps naturally from all ones to zero
   assign cnt_inc = cnt_q + ONE;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (ld_cnt) begin
         cnt_q <= ld_val;
      end else if (adv) begin
         cnt_q <= cnt_inc;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dis_q <= 1'b1;
      end else if (ld_flag) begin
         dis_q <= flag_val;
      end
   end
endmodule

// File: rtl/tick_cmp_unit.sv
module tick_cmp_unit #(
   parameter int CNT_W = 63
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lim_wr,
   input  logic             cnt_wr,
   input  logic [CNT_W-1:0] lim_val,
   input  logic [CNT_W-1:0] cnt_q,
   input  logic [CNT_W-1:0] cnt_inc,
   input  logic             adv,
   input  logic             dis_q,
   output logic             fire
);
   logic [CNT_W-1:0] lim_q;
   logic             armed_q;
   logic             due_q;
   logic             lim_nz;
   logic             reach;

   assign lim_nz = |lim_val;
   // compare against the value the counter takes on this tick
   assign reach  = (cnt_inc >= lim_q);
   assign fire   = adv & armed_q & ~dis_q & (due_q | reach);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lim_q   <= '0;
         armed_q <= 1'b0;
         due_q   <= 1'b0;
      end else if (lim_wr) begin
         lim_q   <= lim_val;
         armed_q <= lim_nz;
         due_q   <= lim_nz & (lim_val <= cnt_q);
      end else if (fire) begin
         armed_q <= 1'b0;
         due_q   <= 1'b0;
      end else if (cnt_wr) begin
         due_q   <= 1'b0;
      end
   end
endmodule

// File: rtl/tick_irq_map.sv
module tick_irq_map #(
   parameter int SI_W   = 17,
   parameter int SI_POS = 0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            fire,
   output logic [SI_W-1:0] softint_set
);
   if (SI_POS >= SI_W || SI_POS < 0) begin : g_bad_pos
      $error("tick_irq_map: SI_POS outside soft-interrupt vector");
   end

   for (genvar i = 0; i < SI_W; i++) begin : g_bit
      if (i == SI_POS) begin : g_live
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) softint_set[i] <= 1'b0;
            else        softint_set[i] <= fire;
         end
      end else begin : g_tie
         assign softint_set[i] = 1'b0;
      end
   end
endmodule

// File: rtl/tick_cmp_timer.sv
module tick_cmp_timer #(
   parameter int                      CNT_W = 63,
   parameter int                      SI_W  = 17,
   parameter tick_cmp_pkg::tick_kind_e KIND = tick_cmp_pkg::TK_CPU
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick_en,
   input  logic               wr_en,
   input  logic               wr_sel,
   input  logic [CNT_W:0]     wr_data,
   output logic [CNT_W:0]     rd_data,
   output logic [SI_W-1:0]    softint_set
);
   localparam int DATA_W = CNT_W + 1;
   localparam int SI_POS = tick_cmp_pkg::softint_pos(KIND);

   if (CNT_W < 2) begin : g_bad_w
      $error("tick_cmp_timer: CNT_W too small");
   end
   if (SI_POS >= SI_W) begin : g_bad_si
      $error("tick_cmp_timer: SI_W cannot hold this role's bit");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_inc;
   logic             dis_q;
   logic             adv;
   logic             cnt_wr;
   logic             lim_wr;
   logic             fire;

   assign cnt_wr = wr_en & ~wr_sel;
   assign lim_wr = wr_en &  wr_sel;
   assign adv    = tick_en & ~wr_en;

   tick_cnt_core #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .adv      (adv),
      .ld_cnt   (cnt_wr),
      .ld_val   (wr_data[CNT_W-1:0]),
      .ld_flag  (wr_en),
      .flag_val (wr_data[DATA_W-1]),
      .cnt_q    (cnt_q),
      .cnt_inc  (cnt_inc),
      .dis_q    (dis_q)
   );

   tick_cmp_unit #(.CNT_W(CNT_W)) u_cmp (
      .clk     (clk),
      .rst_n   (rst_n),
      .lim_wr  (lim_wr),
      .cnt_wr  (cnt_wr),
      .lim_val (wr_data[CNT_W-1:0]),
      .cnt_q   (cnt_q),
      .cnt_inc (cnt_inc),
      .adv     (adv),
      .dis_q   (dis_q),
      .fire    (fire)
   );

   tick_irq_map #(.SI_W(SI_W), .SI_POS(SI_POS)) u_map (
      .clk         (clk),
      .rst_n       (rst_n),
      .fire        (fire),
      .softint_set (softint_set)
   );

   assign rd_data = {dis_q, cnt_q};
endmodule

// File: rtl/tick_cmp_timer_chk.sv
module tick_cmp_timer_chk #(
   parameter int CNT_W = 63,
   parameter int SI_W  = 17
) (
   input logic            clk,
   input logic            rst_n,
   input logic            tick_en,
   input logic            wr_en,
   input logic            wr_sel,
   input logic [CNT_W:0]  wr_data,
   input logic [CNT_W:0]  rd_data,
   input logic [SI_W-1:0] softint_set
);
   p_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(softint_set));

   p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (|softint_set) |=> (softint_set == '0));

   p_needs_tick_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (|softint_set) |-> $past(tick_en && !wr_en));

   p_flag_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (|softint_set) |-> !$past(rd_data[CNT_W]));

   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_en && !wr_en) |=> $stable(rd_data));

   p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_en && !wr_en && rd_data[CNT_W-1:0] != {CNT_W{1'b1}}) |=>
      (rd_data[CNT_W-1:0] == $past(rd_data[CNT_W-1:0]) + 1'b1) && $stable(rd_data[CNT_W]));

   p_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_en && !wr_en && rd_data[CNT_W-1:0] == {CNT_W{1'b1}}) |=>
      (rd_data[CNT_W-1:0] == '0) && (softint_set == '0));

   p_cnt_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_sel) |=> (rd_data == $past(wr_data)));

   p_lim_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel) |=> (rd_data == {$past(wr_data[CNT_W]), $past(rd_data[CNT_W-1:0])}));
endmodule

bind tick_cmp_timer tick_cmp_timer_chk #(.CNT_W(CNT_W), .SI_W(SI_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .tick_en     (tick_en),
   .wr_en       (wr_en),
   .wr_sel      (wr_sel),
   .wr_data     (wr_data),
   .rd_data     (rd_data),
   .softint_set (softint_set)
);

// File: tb/sim_tick_cmp_timer.sv
module sim_tick_cmp_timer;
   localparam logic [63:0] DIS = 64'h8000_0000_0000_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b0;
   logic        wr_en = 1'b0;
   logic        wr_sel = 1'b0;
   logic [63:0] wr_data = '0;
   logic [63:0] rd_data, rd_data1;
   logic [16:0] si0, si1;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   tick_cmp_timer #(.KIND(tick_cmp_pkg::TK_CPU)) u0 (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .rd_data(rd_data), .softint_set(si0));

   tick_cmp_timer #(.KIND(tick_cmp_pkg::TK_SYS)) u1 (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .rd_data(rd_data1), .softint_set(si1));

   task automatic chk(string rq, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", rq, act, exp);
      end
   endtask

   // one register write; optionally with a coincident tick
   task automatic reg_wr(bit sel, logic [63:0] d, bit with_tick = 1'b0);
      wr_en = 1'b1; wr_sel = sel; wr_data = d; tick_en = with_tick;
      @(negedge clk);
      wr_en = 1'b0; tick_en = 1'b0;
   endtask

   // n ticks; expect a pulse only on tick number fire_at (0 = never)
   task automatic run_ticks(int n, int fire_at, string rq);
      tick_en = 1'b1;
      for (int k = 1; k <= n; k++) begin
         @(negedge clk);
         chk(rq, {47'd0, si0}, (k == fire_at) ? 64'h1 : 64'h0);
         chk("R11", {47'd0, si1}, (k == fire_at) ? 64'h10000 : 64'h0);
      end
      tick_en = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1", rd_data, DIS);
      chk("R1", {47'd0, si0}, 64'h0);
      run_ticks(4, 0, "R1");
      chk("R3", rd_data, DIS | 64'd4);
   endtask

   task automatic t_count_rw();
      reg_wr(1'b0, 64'h0000_0123_4567_89AB);
      chk("R2", rd_data, 64'h0000_0123_4567_89AB);
      reg_wr(1'b0, DIS | 64'h55);
      chk("R4", rd_data, DIS | 64'h55);
      repeat (3) @(negedge clk);
      chk("R3", rd_data, DIS | 64'h55);
      run_ticks(5, 0, "R3");
      chk("R3", rd_data, DIS | 64'h5A);
   endtask

   task automatic t_match_rearm();
      reg_wr(1'b0, 64'd0);
      reg_wr(1'b1, 64'd8);
      run_ticks(8, 8, "R5");
      chk("R5", rd_data, 64'd8);
      run_ticks(12, 0, "R9");
      reg_wr(1'b1, 64'd25);
      run_ticks(6, 5, "R9");
      chk("R9", rd_data, 64'd26);
   endtask

   task automatic t_zero_limit();
      reg_wr(1'b0, 64'd0);
      reg_wr(1'b1, 64'd0);
      run_ticks(20, 0, "R6");
      chk("R6", rd_data, 64'd20);
   endtask

   task automatic t_past_limit();
      reg_wr(1'b0, 64'd100);
      reg_wr(1'b1, 64'd40);
      run_ticks(3, 1, "R7");
      chk("R7", rd_data, 64'd103);
      reg_wr(1'b1, 64'd103);
      run_ticks(2, 1, "R7");
   endtask

   task automatic t_disabled();
      reg_wr(1'b0, 64'd0);
      reg_wr(1'b1, DIS | 64'd5);
      chk("R8", rd_data, DIS);
      run_ticks(10, 0, "R8");
      reg_wr(1'b0, 64'd0);
      run_ticks(5, 5, "R8");
   endtask

   task automatic t_wrap();
      reg_wr(1'b0, 64'd0);
      reg_wr(1'b1, 64'd10);
      reg_wr(1'b0, 64'h7FFF_FFFF_FFFF_FFFF);
      run_ticks(1, 0, "R10");
      chk("R10", rd_data, 64'd0);
      run_ticks(10, 10, "R10");
      chk("R10", rd_data, 64'd10);
   endtask

   task automatic t_collide();
      reg_wr(1'b0, 64'd50, 1'b1);
      chk("R12", rd_data, 64'd50);
      reg_wr(1'b0, 64'd0, 1'b1);
      reg_wr(1'b1, 64'd3, 1'b1);
      chk("R12", rd_data, 64'd0);
      chk("R12", {47'd0, si0}, 64'h0);
      run_ticks(3, 3, "R12");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_count_rw();
      t_match_rearm();
      t_zero_limit();
      t_past_limit();
      t_disabled();
      t_wrap();
      t_collide();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      #(20 * 100000);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule